// File: doc/BRIEF.md
# Multi-Domain DMA Reset Sequencer

This block runs in the control clock domain of a DMA engine whose destination and source data paths each have their own clock. It drives one reset and one enable into each data domain. The reset comes from the control side, but each domain receives it through its own synchronizer. The same reset serves two purposes. It brings both domains to a known state after power-up, and it clears stale data and metadata after a transfer has been aborted.

After an abort the enables drop at once. The controller then waits until the data path reports idle, meaning all outstanding bus transactions have been finished. Only then does it assert reset. Reset stays asserted until each domain has counted a minimum number of its own clock cycles with reset high. The controller then releases the destination side and waits for that side to confirm the release. After that it releases the source side, so the sink is always ready before the source can send. At the end it reports that it is ready for a new transfer. Pause and resume only gate the enables, so each domain keeps its state while paused.

Top module: `dma_rst_seq`

## Requirements
- R1: While `rst` is high and right after it, both domain resets are high, both enables are low and `ready` is low. The power-up sequence then runs to `ready` without any request.
- R2: An `abort` in the running or paused state drops both enables. Neither domain reset is asserted while `idle` stays low.
- R3: Each domain reset stays high for at least MIN_CYCLES (default 4) cycles of that domain's own clock. This holds for the power-up sequence and for every abort sequence.
- R4: `dst_rst` is released first. `src_rst` falls only after the controller has seen the release of the destination reset come back from the destination domain.
- R5: A high `pause` while running drops both enables and asserts no reset. When `pause` goes low again, both enables return.
- R6: When a reset sequence completes, `ready` goes high. A `start` pulse while `ready` is high drives both enables high, with both resets low.
- R7: An `abort` has no effect while reset is asserted or while `ready` is high. A `start` has no effect anywhere except in the ready state.
- R8: In each domain, the enable is never high while the reset of that domain is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst | input | 1 | Synchronous active-high reset, control domain |
| dst_clk | input | 1 | Destination data-domain clock |
| src_clk | input | 1 | Source data-domain clock |
| start | input | 1 | Start pulse for a new transfer |
| abort | input | 1 | Abort pulse for the current transfer |
| pause | input | 1 | Level; high holds the transfer paused |
| idle | input | 1 | Data path has no outstanding transactions, synchronous to `clk` |
| ready | output | 1 | Sequencer is in the shutdown state and accepts `start` |
| dst_rst | output | 1 | Reset in the destination domain |
| dst_en | output | 1 | Enable in the destination domain |
| src_rst | output | 1 | Reset in the source domain |
| src_en | output | 1 | Enable in the source domain |

## Verification
The assertions assume three things about the inputs. `idle` is already synchronous to the control clock. `start` and `abort` are single-cycle pulses. Each data clock keeps running while a sequence is in progress, because every wait in the controller depends on feedback from the data domains. The stimulus drives all inputs on falling control-clock edges. It uses two data clocks at non-integer ratios to the control clock. It raises `idle` only when the bench itself decides that the data path has finished, and it sweeps the idle delay and the pause pattern over several abort sequences.

// File: rtl/dma_rst_pkg.sv
package dma_rst_pkg;
  typedef enum logic [7:0] {
    ST_STARTUP  = 8'b0000_0001,
    ST_RUN      = 8'b0000_0010,
    ST_PAUSED   = 8'b0000_0100,
    ST_WAIT     = 8'b0000_1000,
    ST_ASSERT   = 8'b0001_0000,
    ST_REL_DST  = 8'b0010_0000,
    ST_REL_SRC  = 8'b0100_0000,
    ST_SHUT     = 8'b1000_0000
  } seq_state_t;

  localparam int DOM_DST = 0;
  localparam int DOM_SRC = 1;
  localparam int N_DOM   = 2;
endpackage

// File: rtl/dma_dom_link.sv
// Carries reset and enable into one data domain and returns status.
module dma_dom_link #(
  parameter int STAGES     = 2,
  parameter int MIN_CYCLES = 4
) (
  input  logic clk,
  input  logic dclk,
  input  logic rst_req,
  input  logic en_req,
  output logic rst_o,
  output logic en_o,
  output logic held_c,
  output logic rst_fb_c
);
  localparam int CW = $clog2(MIN_CYCLES + 1);

  // data-domain side; power-up values hold the domain in reset
  logic [STAGES-1:0] rst_sh  = '1;
  logic [STAGES-1:0] en_sh   = '0;
  logic [CW-1:0]     cnt     = '0;
  logic              held_d  = 1'b0;
  logic              armed   = 1'b0;

  always_ff @(posedge dclk) begin
    rst_sh <= {rst_sh[STAGES-2:0], rst_req};
    en_sh  <= {en_sh[STAGES-2:0], en_req};
    armed  <= 1'b1;
    if (!rst_sh[STAGES-2]) begin
      cnt    <= '0;
      held_d <= 1'b0;
    end else begin
      if (cnt != CW'(MIN_CYCLES)) cnt <= cnt + 1'b1;
      held_d <= (cnt >= CW'(MIN_CYCLES - 1));
    end
  end

  assign rst_o = rst_sh[STAGES-1];
  assign en_o  = en_sh[STAGES-1];

  // control-domain side
  logic [STAGES-1:0] fb_sh   = '1;
  logic [STAGES-1:0] held_sh = '0;

  always_ff @(posedge clk) begin
    fb_sh   <= {fb_sh[STAGES-2:0], rst_o};
    held_sh <= {held_sh[STAGES-2:0], held_d};
  end

  assign rst_fb_c = fb_sh[STAGES-1];
  assign held_c   = held_sh[STAGES-1];

  // R3
  min_width_chk: assert property (@(posedge dclk) disable iff (!armed)
    $fell(rst_o) |-> $past(cnt) == CW'(MIN_CYCLES));

  // R8
  en_in_rst_chk: assert property (@(posedge dclk) disable iff (!armed)
    en_o |-> !rst_o);
endmodule

// File: rtl/dma_rst_ctrl.sv
// Control-domain sequencing state machine.
module dma_rst_ctrl
  import dma_rst_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic abort,
  input  logic pause,
  input  logic idle,
  input  logic dst_held,
  input  logic src_held,
  input  logic dst_fb,
  input  logic src_fb,
  output logic dst_rst_req,
  output logic src_rst_req,
  output logic en_req,
  output logic ready
);
  seq_state_t state, nxt;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_STARTUP, ST_ASSERT: if (dst_held && src_held) nxt = ST_REL_DST;
      ST_RUN:     if (abort) nxt = ST_WAIT; else if (pause) nxt = ST_PAUSED;
      ST_PAUSED:  if (abort) nxt = ST_WAIT; else if (!pause) nxt = ST_RUN;
      ST_WAIT:    if (idle) nxt = ST_ASSERT;
      ST_REL_DST: if (!dst_fb) nxt = ST_REL_SRC;
      ST_REL_SRC: if (!src_fb) nxt = ST_SHUT;
      ST_SHUT:    if (start) nxt = ST_RUN;
      default:    nxt = ST_STARTUP;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_STARTUP;
      dst_rst_req <= 1'b1;
      src_rst_req <= 1'b1;
      en_req      <= 1'b0;
      ready       <= 1'b0;
    end else begin
      state       <= nxt;
      dst_rst_req <= (nxt == ST_STARTUP) || (nxt == ST_ASSERT);
      src_rst_req <= (nxt == ST_STARTUP) || (nxt == ST_ASSERT) || (nxt == ST_REL_DST);
      en_req      <= (nxt == ST_RUN);
      ready       <= (nxt == ST_SHUT);
    end
  end

  // R3
  hold_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(dst_rst_req) |-> $past(dst_held && src_held));

  // R4
  rel_order_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(src_rst_req) |-> !dst_fb);

  // R2
  idle_gate_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(dst_rst_req) |-> $past(idle));

  // R5
  pause_chk: assert property (@(posedge clk) disable iff (rst)
    (en_req && pause && !abort) |=> (!en_req && !dst_rst_req && !src_rst_req));

  // R7
  abort_shut_chk: assert property (@(posedge clk) disable iff (rst)
    (ready && abort && !start) |=> ready);

  // R7
  abort_rst_chk: assert property (@(posedge clk) disable iff (rst)
    (dst_rst_req && !(dst_held && src_held)) |=> dst_rst_req);
endmodule

// File: rtl/dma_rst_seq.sv
module dma_rst_seq
  import dma_rst_pkg::*;
#(
  parameter int STAGES     = 2,
  parameter int MIN_CYCLES = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic dst_clk,
  input  logic src_clk,
  input  logic start,
  input  logic abort,
  input  logic pause,
  input  logic idle,
  output logic ready,
  output logic dst_rst,
  output logic dst_en,
  output logic src_rst,
  output logic src_en
);
  logic [N_DOM-1:0] dclk, rst_req, held, fb, rst_d, en_d;
  logic             en_req;

  assign dclk[DOM_DST] = dst_clk;
  assign dclk[DOM_SRC] = src_clk;

  dma_rst_ctrl u_ctrl (
    .clk(clk), .rst(rst), .start(start), .abort(abort), .pause(pause),
    .idle(idle), .dst_held(held[DOM_DST]), .src_held(held[DOM_SRC]),
    .dst_fb(fb[DOM_DST]), .src_fb(fb[DOM_SRC]),
    .dst_rst_req(rst_req[DOM_DST]), .src_rst_req(rst_req[DOM_SRC]),
    .en_req(en_req), .ready(ready)
  );

  for (genvar i = 0; i < N_DOM; i++) begin : g_dom
    dma_dom_link #(.STAGES(STAGES), .MIN_CYCLES(MIN_CYCLES)) u_link (
      .clk(clk), .dclk(dclk[i]), .rst_req(rst_req[i]), .en_req(en_req),
      .rst_o(rst_d[i]), .en_o(en_d[i]), .held_c(held[i]), .rst_fb_c(fb[i])
    );
  end

  assign dst_rst = rst_d[DOM_DST];
  assign src_rst = rst_d[DOM_SRC];
  assign dst_en  = en_d[DOM_DST];
  assign src_en  = en_d[DOM_SRC];
endmodule

// File: tb/sim_dma_rst_seq.sv
`timescale 1ns/1ps
module sim_dma_rst_seq;
  localparam int MINC = 4;

  logic clk = 1'b0, dst_clk = 1'b0, src_clk = 1'b0;
  logic rst = 1'b1, start = 1'b0, abort = 1'b0, pause = 1'b0, idle = 1'b0;
  logic ready, dst_rst, dst_en, src_rst, src_en;

  always #5  clk     = ~clk;
  always #7  dst_clk = ~dst_clk;
  always #19 src_clk = ~src_clk;

  dma_rst_seq #(.MIN_CYCLES(MINC)) u0 (
    .clk(clk), .rst(rst), .dst_clk(dst_clk), .src_clk(src_clk),
    .start(start), .abort(abort), .pause(pause), .idle(idle),
    .ready(ready), .dst_rst(dst_rst), .dst_en(dst_en),
    .src_rst(src_rst), .src_en(src_en)
  );

  int  n_tests = 0, n_fail = 0;
  int  dcnt = 0, scnt = 0, d_width = 0, s_width = 0;
  realtime t_dst = 0, t_src = 0;

  always @(negedge dst_clk) begin
    if (dst_rst) dcnt = dcnt + 1;
    else if (dcnt != 0) begin d_width = dcnt; dcnt = 0; end
  end
  always @(negedge src_clk) begin
    if (src_rst) scnt = scnt + 1;
    else if (scnt != 0) begin s_width = scnt; scnt = 0; end
  end
  always @(negedge dst_rst) t_dst = $realtime;
  always @(negedge src_rst) t_src = $realtime;

  task automatic chk(input string req, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_start();
    start = 1'b1; cyc(1); start = 1'b0;
  endtask

  task automatic pulse_abort();
    abort = 1'b1; cyc(1); abort = 1'b0;
  endtask

  task automatic wait_ready(input string req);
    int k = 0;
    while (!ready && k < 2000) begin cyc(1); k++; end
    chk(req, int'(ready), 1);
  endtask

  // Checks after a completed reset sequence: widths, order, outputs.
  task automatic check_seq();
    cyc(10);
    chk("R3 dst width ok", int'(d_width >= MINC), 1);
    chk("R3 src width ok", int'(s_width >= MINC), 1);
    chk("R4 dst before src", int'(t_dst < t_src), 1);
    chk("R8 en low at ready", int'({dst_en, src_en}), 0);
    chk("R6 rst low at ready", int'({dst_rst, src_rst}), 0);
  endtask

  initial begin
    #1_000_000;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail);
    $finish;
  end

  initial begin
    cyc(6);
    // R1 reset state while rst is held
    chk("R1 resets high", int'({dst_rst, src_rst}), 3);
    chk("R1 enables low", int'({dst_en, src_en}), 0);
    chk("R1 ready low", int'(ready), 0);
    rst = 1'b0;
    cyc(1);
    chk("R1 resets high after rst", int'({dst_rst, src_rst}), 3);
    wait_ready("R1 power-up reaches ready");
    check_seq();

    for (int d = 0; d < 6; d++) begin
      // R7 abort ignored in ready state
      pulse_abort();
      cyc(12);
      chk("R7 abort in ready ignored", int'(ready), 1);
      chk("R7 abort in ready no reset", int'({dst_rst, src_rst}), 0);

      pulse_start();
      cyc(20);
      chk("R6 start enables", int'({dst_en, src_en}), 3);
      chk("R6 ready cleared", int'(ready), 0);

      if (d % 2 == 1) begin
        pause = 1'b1;
        cyc(20);
        chk("R5 paused enables low", int'({dst_en, src_en}), 0);
        chk("R5 paused no reset", int'({dst_rst, src_rst}), 0);
        pulse_start();
        cyc(20);
        chk("R7 start in pause ignored", int'({dst_en, src_en}), 0);
        if (d != 3) begin
          pause = 1'b0;
          cyc(20);
          chk("R5 resume enables", int'({dst_en, src_en}), 3);
        end
      end

      // R2 abort then hold idle low
      d_width = 0; s_width = 0;
      pulse_abort();
      pause = 1'b0;
      cyc(20 + 10 * d);
      chk("R2 enables dropped", int'({dst_en, src_en}), 0);
      chk("R2 no reset before idle", int'({dst_rst, src_rst}), 0);
      pulse_start();
      cyc(10);
      chk("R7 start in wait ignored", int'({dst_en, src_en, ready}), 0);

      idle = 1'b1;
      begin
        int k = 0;
        while (!dst_rst && k < 100) begin cyc(1); k++; end
      end
      chk("R1 reset reused after abort", int'(dst_rst), 1);
      pulse_abort();
      cyc(2);
      chk("R7 abort in reset ignored", int'(ready), 0);
      wait_ready("R6 ready after abort sequence");
      idle = 1'b0;
      check_seq();
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule